// File: doc/BRIEF.md
# Physical Address Router with Low-Memory Hole Relocation

This block sits between a processor's physical-address request stream and the targets behind it. Every request carries a 48-bit physical address, a read/write flag and a valid strobe. One clock later the block returns a target code, a hit flag and, for requests that land in DRAM, the DRAM-linear address to present to the memory controller. The first megabyte has a fixed legacy layout. Main DRAM then runs up to a configurable top-of-low-memory boundary. The span from that boundary up to 4 GB is given to devices, and two small fixed device windows near the top of that span override the general device window.

DRAM that the low hole would otherwise hide is not lost. It is presented again starting at exactly 4 GB, and the block translates any request in that relocated window back to the DRAM-linear address it stands for. A second configuration input marks where the 64-bit device window begins. Any address that falls between the end of the relocated DRAM and that base matches nothing and is reported as a miss. A miss never selects DRAM.

Top module: `addr_route_decoder`

## Requirements
- R1: Each response appears exactly one cycle after its request. rsp_valid is high in the cycle after req_valid was high and low otherwise, and rsp_write repeats the request's write flag.
- R2: Addresses 0x0 to 0x9FFFF select DRAM (code 1). The DRAM address equals the request address.
- R3: Addresses 0xA0000 to 0xBFFFF select the legacy frame buffer (code 2). Addresses 0xC0000 to 0xFFFFF select the boot ROM (code 3).
- R4: Addresses from 0x100000 up to cfg_tolm-1 select DRAM (code 1), with the DRAM address equal to the request address.
- R5: Addresses from cfg_tolm up to 0xFFFFFFFF that are outside both fixed device windows select the 32-bit device window (code 4). DRAM is never selected there.
- R6: 0xFED00000 to 0xFED03FFF selects the timer block (code 5), and 0xFEE00000 to 0xFEE00FFF selects the interrupt controller (code 6). Both override R4 and R5.
- R7: Addresses from 0x1_0000_0000 up to, but not including, 0x1_0000_0000 + (0x1_0000_0000 - cfg_tolm) select relocated DRAM (code 8). The DRAM address is request - 0x1_0000_0000 + cfg_tolm.
- R8: Addresses at or above cfg_hmmio_base, and beyond the relocated window, select the 64-bit device window (code 7).
- R9: Addresses above the relocated window and below cfg_hmmio_base give code 0 with rsp_hit low. Every non-zero code gives rsp_hit high. The DRAM address is 0 for every code other than 1 and 8.
- R10: While reset is applied and until the first request, rsp_valid, rsp_hit, rsp_write, rsp_target and rsp_dram_addr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_tolm | input | ADDR_W | Top of low DRAM; also where the 32-bit device hole starts |
| cfg_hmmio_base | input | ADDR_W | First address of the 64-bit device window |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | Request is a write |
| req_addr | input | ADDR_W | Physical address of the request |
| rsp_valid | output | 1 | Decode result is valid |
| rsp_write | output | 1 | Write flag of the decoded request |
| rsp_target | output | 4 | Target code as listed in R2 to R9 |
| rsp_hit | output | 1 | Address matched a target |
| rsp_dram_addr | output | ADDR_W | DRAM-linear address for codes 1 and 8, else 0 |

## Verification
The properties assume that cfg_tolm lies between 0x100000 and 0x1_0000_0000. They also assume that cfg_hmmio_base is no lower than the end of the relocated window, and that both configuration inputs hold steady while a request is being decoded. The stimulus only writes configurations that satisfy these limits. It changes a configuration only after two idle cycles, so no decoded result is in flight when it does. Within each configuration it probes both sides of every region edge, including the edges that move with cfg_tolm and cfg_hmmio_base, and then sends a spread of pseudo-random addresses drawn at several magnitudes.

// File: rtl/addr_route_pkg.sv
package addr_route_pkg;

   localparam int unsigned TGT_W = 4;

   localparam logic [TGT_W-1:0] TGT_MISS    = 4'd0;
   localparam logic [TGT_W-1:0] TGT_DRAM    = 4'd1;
   localparam logic [TGT_W-1:0] TGT_FBUF    = 4'd2;
   localparam logic [TGT_W-1:0] TGT_BROM    = 4'd3;
   localparam logic [TGT_W-1:0] TGT_DEV32   = 4'd4;
   localparam logic [TGT_W-1:0] TGT_TIMER   = 4'd5;
   localparam logic [TGT_W-1:0] TGT_INTCTL  = 4'd6;
   localparam logic [TGT_W-1:0] TGT_DEV64   = 4'd7;
   localparam logic [TGT_W-1:0] TGT_RELOC   = 4'd8;

   localparam logic [63:0] FOUR_GIB     = 64'h0000_0001_0000_0000;
   localparam logic [63:0] LEGACY_LIMIT = 64'h0000_0000_0010_0000;

   // fixed windows: low legacy layout plus two device windows in the hole
   localparam int unsigned NUM_FIXED = 5;

   function automatic logic [63:0] fixed_base(input int unsigned idx);
      case (idx)
         0: fixed_base = 64'h0000_0000_0000_0000;
         1: fixed_base = 64'h0000_0000_000A_0000;
         2: fixed_base = 64'h0000_0000_000C_0000;
         3: fixed_base = 64'h0000_0000_FED0_0000;
         default: fixed_base = 64'h0000_0000_FEE0_0000;
      endcase
   endfunction

   function automatic logic [63:0] fixed_span(input int unsigned idx);
      case (idx)
         0: fixed_span = 64'h0000_0000_000A_0000;
         1: fixed_span = 64'h0000_0000_0002_0000;
         2: fixed_span = 64'h0000_0000_0004_0000;
         3: fixed_span = 64'h0000_0000_0000_4000;
         default: fixed_span = 64'h0000_0000_0000_1000;
      endcase
   endfunction

   function automatic logic [TGT_W-1:0] fixed_tgt(input int unsigned idx);
      case (idx)
         0: fixed_tgt = TGT_DRAM;
         1: fixed_tgt = TGT_FBUF;
         2: fixed_tgt = TGT_BROM;
         3: fixed_tgt = TGT_TIMER;
         default: fixed_tgt = TGT_INTCTL;
      endcase
   endfunction

endpackage

// File: rtl/addr_window_match.sv
module addr_window_match #(
   parameter int unsigned ADDR_W = 48,
   parameter logic [63:0] BASE   = 64'h0,
   parameter logic [63:0] SPAN   = 64'h1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam logic [63:0] LAST = BASE + SPAN - 64'd1;

   logic [63:0] addr_ext;
   assign addr_ext = 64'(addr);

   if (SPAN == 64'd0) begin : g_bad_span
      $error("addr_window_match: SPAN must be non-zero");
   end

   if (BASE == 64'd0) begin : g_from_zero
      assign hit = (addr_ext <= LAST);
   end else begin : g_bounded
      assign hit = (addr_ext >= BASE) && (addr_ext <= LAST);
   end

endmodule

// File: rtl/addr_fixed_map.sv
module addr_fixed_map
   import addr_route_pkg::*;
#(
   parameter int unsigned ADDR_W = 48
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              any_hit,
   output logic [TGT_W-1:0]  tgt
);
   logic [NUM_FIXED-1:0] win_hit;

   for (genvar gi = 0; gi < NUM_FIXED; gi++) begin : g_win
      addr_window_match #(
         .ADDR_W (ADDR_W),
         .BASE   (fixed_base(gi)),
         .SPAN   (fixed_span(gi))
      ) u_match (
         .addr (addr),
         .hit  (win_hit[gi])
      );
   end

   // windows are disjoint, so OR-merging the codes is safe
   always_comb begin
      tgt = TGT_MISS;
      for (int i = 0; i < NUM_FIXED; i++) begin
         if (win_hit[i]) tgt = tgt | fixed_tgt(i);
      end
   end

   assign any_hit = |win_hit;

endmodule

// File: rtl/addr_reloc_xlate.sv
module addr_reloc_xlate
   import addr_route_pkg::*;
#(
   parameter int unsigned ADDR_W = 48
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] tolm,
   output logic              in_win,
   output logic [ADDR_W-1:0] dram_addr
);
   localparam logic [ADDR_W-1:0] BASE4G = ADDR_W'(FOUR_GIB);

   logic [ADDR_W-1:0] hole_size;
   logic [ADDR_W-1:0] win_end;
   logic [ADDR_W-1:0] offset;

   assign hole_size = BASE4G - tolm;
   assign win_end   = BASE4G + hole_size;
   assign offset    = addr - BASE4G;

   assign in_win    = (addr >= BASE4G) && (addr < win_end);
   assign dram_addr = offset + tolm;

endmodule

// File: rtl/addr_route_select.sv
module addr_route_select
   import addr_route_pkg::*;
#(
   parameter int unsigned ADDR_W = 48
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] tolm,
   input  logic [ADDR_W-1:0] hmmio_base,
   input  logic              fix_hit,
   input  logic [TGT_W-1:0]  fix_tgt,
   input  logic              reloc_hit,
   input  logic [ADDR_W-1:0] reloc_addr,
   output logic [TGT_W-1:0]  tgt,
   output logic              hit,
   output logic [ADDR_W-1:0] dram_addr
);
   localparam logic [ADDR_W-1:0] BASE4G = ADDR_W'(FOUR_GIB);

   always_comb begin
      tgt       = TGT_MISS;
      hit       = 1'b0;
      dram_addr = '0;
      if (fix_hit) begin
         tgt = fix_tgt;
         hit = 1'b1;
         if (fix_tgt == TGT_DRAM) dram_addr = addr;
      end else if (addr < tolm) begin
         tgt       = TGT_DRAM;
         hit       = 1'b1;
         dram_addr = addr;
      end else if (addr < BASE4G) begin
         tgt = TGT_DEV32;
         hit = 1'b1;
      end else if (reloc_hit) begin
         tgt       = TGT_RELOC;
         hit       = 1'b1;
         dram_addr = reloc_addr;
      end else if (addr >= hmmio_base) begin
         tgt = TGT_DEV64;
         hit = 1'b1;
      end
   end

endmodule

// File: rtl/addr_route_decoder.sv
module addr_route_decoder
   import addr_route_pkg::*;
#(
   parameter int unsigned ADDR_W = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_tolm,
   input  logic [ADDR_W-1:0] cfg_hmmio_base,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic              rsp_write,
   output logic [3:0]        rsp_target,
   output logic              rsp_hit,
   output logic [ADDR_W-1:0] rsp_dram_addr
);
   if (ADDR_W < 33 || ADDR_W > 60) begin : g_bad_width
      $error("addr_route_decoder: ADDR_W must lie in 33..60");
   end
   if (TGT_W != 4) begin : g_bad_tgt
      $error("addr_route_decoder: target code must be 4 bits");
   end

   logic              fix_hit;
   logic [TGT_W-1:0]  fix_tgt;
   logic              reloc_hit;
   logic [ADDR_W-1:0] reloc_addr;
   logic [TGT_W-1:0]  nxt_tgt;
   logic              nxt_hit;
   logic [ADDR_W-1:0] nxt_dram;

   addr_fixed_map #(.ADDR_W(ADDR_W)) u_fixed (
      .addr    (req_addr),
      .any_hit (fix_hit),
      .tgt     (fix_tgt)
   );

   addr_reloc_xlate #(.ADDR_W(ADDR_W)) u_reloc (
      .addr      (req_addr),
      .tolm      (cfg_tolm),
      .in_win    (reloc_hit),
      .dram_addr (reloc_addr)
   );

   addr_route_select #(.ADDR_W(ADDR_W)) u_select (
      .addr       (req_addr),
      .tolm       (cfg_tolm),
      .hmmio_base (cfg_hmmio_base),
      .fix_hit    (fix_hit),
      .fix_tgt    (fix_tgt),
      .reloc_hit  (reloc_hit),
      .reloc_addr (reloc_addr),
      .tgt        (nxt_tgt),
      .hit        (nxt_hit),
      .dram_addr  (nxt_dram)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid     <= 1'b0;
         rsp_write     <= 1'b0;
         rsp_target    <= TGT_MISS;
         rsp_hit       <= 1'b0;
         rsp_dram_addr <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_write     <= req_write;
            rsp_target    <= nxt_tgt;
            rsp_hit       <= nxt_hit;
            rsp_dram_addr <= nxt_dram;
         end
      end
   end

endmodule

// File: rtl/addr_route_checker.sv
module addr_route_checker #(
   parameter int unsigned ADDR_W = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cfg_tolm,
   input logic [ADDR_W-1:0] cfg_hmmio_base,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic              rsp_write,
   input logic [3:0]        rsp_target,
   input logic              rsp_hit,
   input logic [ADDR_W-1:0] rsp_dram_addr
);
   localparam logic [ADDR_W-1:0] C_4G    = ADDR_W'(64'h1_0000_0000);
   localparam logic [ADDR_W-1:0] C_1M    = ADDR_W'(64'h10_0000);
   localparam logic [ADDR_W-1:0] C_FBUF  = ADDR_W'(64'hA_0000);
   localparam logic [ADDR_W-1:0] C_BROM  = ADDR_W'(64'hC_0000);
   localparam logic [ADDR_W-1:0] C_TIMER = ADDR_W'(64'hFED0_0000);

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   a_r1_write_echo: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_write == $past(req_write)));

   a_r2_conv_dram: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr < C_FBUF) |=>
         (rsp_target == 4'd1 && rsp_dram_addr == $past(req_addr)));

   a_r3_frame_buf: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr >= C_FBUF && req_addr < C_BROM) |=> (rsp_target == 4'd2));
   a_r3_boot_rom: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr >= C_BROM && req_addr < C_1M) |=> (rsp_target == 4'd3));

   a_r5_hole_device: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr >= cfg_tolm && req_addr >= C_1M && req_addr < C_TIMER) |=>
         (rsp_target == 4'd4 && rsp_dram_addr == '0));

   a_r7_reloc_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_target == 4'd8) |->
         (rsp_dram_addr >= cfg_tolm && rsp_dram_addr < C_4G));

   a_r9_miss_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_target == 4'd0) |-> (!rsp_hit && rsp_dram_addr == '0));
   a_r9_hit_has_code: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |-> (rsp_target != 4'd0));

   a_r10_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (!rsp_valid && !rsp_hit));

endmodule

bind addr_route_decoder addr_route_checker #(.ADDR_W(ADDR_W)) u_route_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_tolm       (cfg_tolm),
   .cfg_hmmio_base (cfg_hmmio_base),
   .req_valid      (req_valid),
   .req_write      (req_write),
   .req_addr       (req_addr),
   .rsp_valid      (rsp_valid),
   .rsp_write      (rsp_write),
   .rsp_target     (rsp_target),
   .rsp_hit        (rsp_hit),
   .rsp_dram_addr  (rsp_dram_addr)
);

// File: tb/addr_route_decoder_tb.sv
module addr_route_decoder_tb_top;
   localparam int unsigned AW = 48;
   localparam logic [63:0] G4 = 64'h1_0000_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] cfg_tolm = '0;
   logic [AW-1:0] cfg_hmmio_base = '0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          rsp_valid;
   logic          rsp_write;
   logic [3:0]    rsp_target;
   logic          rsp_hit;
   logic [AW-1:0] rsp_dram_addr;

   int   n_checks = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;
   logic [63:0] cur_tolm;
   logic [63:0] cur_hb;

   always #4 clk = ~clk;

   addr_route_decoder #(.ADDR_W(AW)) dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .cfg_tolm       (cfg_tolm),
      .cfg_hmmio_base (cfg_hmmio_base),
      .req_valid      (req_valid),
      .req_write      (req_write),
      .req_addr       (req_addr),
      .rsp_valid      (rsp_valid),
      .rsp_write      (rsp_write),
      .rsp_target     (rsp_target),
      .rsp_hit        (rsp_hit),
      .rsp_dram_addr  (rsp_dram_addr)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   // reference decode from the requirement text
   task automatic ref_decode(input logic [63:0] a, output int tgt,
                             output logic [63:0] da, output string tag);
      logic [63:0] reloc_end;
      reloc_end = G4 + (G4 - cur_tolm);
      da = 64'd0;
      if (a < 64'hA_0000) begin tgt = 1; da = a; tag = "R2"; end
      else if (a < 64'hC_0000) begin tgt = 2; tag = "R3"; end
      else if (a < 64'h10_0000) begin tgt = 3; tag = "R3"; end
      else if (a >= 64'hFED0_0000 && a <= 64'hFED0_3FFF) begin tgt = 5; tag = "R6"; end
      else if (a >= 64'hFEE0_0000 && a <= 64'hFEE0_0FFF) begin tgt = 6; tag = "R6"; end
      else if (a < cur_tolm) begin tgt = 1; da = a; tag = "R4"; end
      else if (a < G4) begin tgt = 4; tag = "R5"; end
      else if (a < reloc_end) begin tgt = 8; da = a - G4 + cur_tolm; tag = "R7"; end
      else if (a >= cur_hb) begin tgt = 7; tag = "R8"; end
      else begin tgt = 0; tag = "R9"; end
   endtask

   task automatic probe(input logic [63:0] a, input logic wr);
      int          et;
      logic [63:0] ed;
      string       tag;
      ref_decode(a, et, ed, tag);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a[AW-1:0];
      req_write = wr;
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid === 1'b1, "R1", "rsp_valid", 64'(rsp_valid), 64'd1);
      chk(rsp_write === wr, "R1", "rsp_write", 64'(rsp_write), 64'(wr));
      chk(rsp_target === 4'(et), tag, $sformatf("target @0x%0h", a), 64'(rsp_target), 64'(et));
      chk(rsp_hit === (et != 0), (et == 0) ? "R9" : tag, $sformatf("hit @0x%0h", a),
          64'(rsp_hit), 64'(et != 0));
      chk(64'(rsp_dram_addr) === ed, (et == 1 || et == 8) ? tag : "R9",
          $sformatf("dram addr @0x%0h", a), 64'(rsp_dram_addr), ed);
   endtask

   task automatic set_cfg(input logic [63:0] tolm, input logic [63:0] hb);
      @(negedge clk);
      @(negedge clk);
      chk(rsp_valid === 1'b0, "R1", "idle rsp_valid", 64'(rsp_valid), 64'd0);
      cfg_tolm       = tolm[AW-1:0];
      cfg_hmmio_base = hb[AW-1:0];
      cur_tolm       = tolm;
      cur_hb         = hb;
      @(negedge clk);
   endtask

   function automatic logic [63:0] next_rand(input logic [63:0] s);
      logic [63:0] x;
      x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 7);
      x = x ^ (x << 17);
      return x;
   endfunction

   task automatic sweep_cfg(input logic [63:0] tolm, input logic [63:0] hb);
      logic [63:0] edges [22];
      logic [63:0] reloc_end;
      set_cfg(tolm, hb);
      reloc_end = G4 + (G4 - tolm);
      edges = '{64'h0, 64'hA_0000, 64'hC_0000, 64'h10_0000, tolm, 64'hFED0_0000,
                64'hFED0_4000, 64'hFEE0_0000, 64'hFEE0_1000, G4, reloc_end, hb,
                64'h8000_0000, 64'hFEF0_0000, 64'h2_0000_0000, 64'h40_0000_0000,
                64'hFFFF_FFFF_FFFF, 64'h5_5555, 64'h1234_5678, 64'hFED0_2000,
                64'hFEE0_0800, 64'h7_0000_0000};
      foreach (edges[k]) begin
         for (int d = -1; d <= 1; d++) begin
            logic [63:0] a;
            a = (edges[k] + 64'(d)) & 64'hFFFF_FFFF_FFFF;
            probe(a, 1'(k + d));
         end
      end
      for (int n = 0; n < 1200; n++) begin
         logic [63:0] a;
         lfsr = next_rand(lfsr);
         case (lfsr[63:62])
            2'd0: a = lfsr & 64'hF_FFFF;
            2'd1: a = lfsr & 64'hFFFF_FFFF;
            2'd2: a = lfsr & 64'h3_FFFF_FFFF;
            default: a = lfsr & 64'hFFFF_FFFF_FFFF;
         endcase
         probe(a, lfsr[5]);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: outputs quiet during reset
      chk(rsp_valid === 1'b0, "R10", "reset rsp_valid", 64'(rsp_valid), 64'd0);
      chk(rsp_hit === 1'b0, "R10", "reset rsp_hit", 64'(rsp_hit), 64'd0);
      chk(rsp_target === 4'd0, "R10", "reset rsp_target", 64'(rsp_target), 64'd0);
      chk(rsp_write === 1'b0, "R10", "reset rsp_write", 64'(rsp_write), 64'd0);
      chk(rsp_dram_addr === '0, "R10", "reset rsp_dram_addr", 64'(rsp_dram_addr), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rsp_valid === 1'b0, "R10", "post-reset rsp_valid", 64'(rsp_valid), 64'd0);
      sweep_cfg(64'hC000_0000, 64'h80_0000_0000);
      sweep_cfg(64'h8000_0000, 64'h1_8000_0000);
      sweep_cfg(64'h1_0000_0000, 64'h4_0000_0000);
      sweep_cfg(64'h10_0000, 64'h2_0000_0000);
      sweep_cfg(64'hE000_0000, 64'hFFFF_FFFF_FFFF);
      set_cfg(cur_tolm, cur_hb);
      if (!done) begin
         done = 1'b1;
         summary();
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual 1 expected 0");
         summary();
         $finish;
      end
   end

endmodule